// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully-associative address translation buffer. It maps a 40-bit virtual address, tagged with an 8-bit address-space identifier, to a 36-bit physical address. Every entry describes two neighbouring pages of the same size, an even page and an odd page, and holds a separate physical frame number and valid bit for each. Each entry sets its own page size, from 4 KB to 16 MB in powers of four. All entries are compared in parallel, and the lookup result is produced combinationally in the same cycle.

Refill logic outside the block loads entries through a synchronous write port. That logic either names the target slot or lets the block supply a victim slot. The victim slot comes from a free-running down-counter that sweeps from the top entry down to a programmable floor and then wraps, so slots below the floor stay pinned. A lookup reports exactly one outcome: a hit with a translation, a miss when no tag matches, or an invalid-page fault when the tag matches but the selected half is not valid. A separate flag reports when more than one entry matches.

Top module: `tlb_pair_xlate`

## Requirements
- R1: Reset clears every entry, so any lookup reports a miss, and it sets the victim pointer `rnd_idx` to NUM_ENTRIES-1 (47).
- R2: For a 4 KB entry (size code 0), a hit on virtual address bit 12 = 0 returns {pfn_even, va[11:0]}, and a hit on bit 12 = 1 returns {pfn_odd, va[11:0]}.
- R3: Size code k (0..6) selects a page of 4 KB·4^k. The tag ignores stored and virtual bits [12+2k:13], and the half is chosen by va[12+2k]. The low 12+2k address bits pass through to the physical address and the frame bits above them are used. Code 7 behaves as code 6. A change of va bit 13+2k gives a miss.
- R4: A tag matches only if the identifier equals `lk_asid`, unless the entry's global bit is set, in which case any identifier matches.
- R5: When no entry matches, `lk_miss`=1, `lk_hit`=0, `lk_inval`=0, `lk_multi`=0 and `lk_pa`=0.
- R6: An entry with both valid bits clear never matches. If the tag matches but the selected half's valid bit is clear, `lk_inval`=1, `lk_hit`=0, `lk_miss`=0 and `lk_pa`=0. Exactly one of hit, miss and invalid is high at any time.
- R7: An indexed write (`wr_random`=0) replaces the entry at `wr_idx` at the clock edge, and the new entry is visible to lookups from then on. A `wr_idx` >= NUM_ENTRIES writes nothing.
- R8: `rnd_idx` decrements once per clock. When it reaches the floor it wraps to NUM_ENTRIES-1. A floor load (`floor_we`) sets the floor to `floor_val`, clamped to NUM_ENTRIES-1, and restarts the pointer at NUM_ENTRIES-1.
- R9: A random write (`wr_random`=1) replaces the entry at the `rnd_idx` value present at that clock edge, and `wr_idx` is ignored.
- R10: When several entries match, `lk_multi`=1 and the lowest-index matching entry supplies `lk_idx`, the outcome and the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 40 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Valid translation found |
| lk_miss | output | 1 | No entry matched |
| lk_inval | output | 1 | Tag matched, selected half not valid |
| lk_multi | output | 1 | More than one entry matched |
| lk_idx | output | 6 | Index of the entry used (0 on miss) |
| lk_pa | output | 36 | Physical address (0 unless hit) |
| wr_en | input | 1 | Write strobe |
| wr_random | input | 1 | 1: write at rnd_idx, 0: write at wr_idx |
| wr_idx | input | 6 | Explicit write slot |
| wr_vpn2 | input | 27 | Virtual pair number (va[39:13]) |
| wr_asid | input | 8 | Entry identifier |
| wr_global | input | 1 | Entry ignores identifier |
| wr_size | input | 3 | Page size code |
| wr_pfn0 | input | 24 | Even-page frame number |
| wr_v0 | input | 1 | Even-page valid |
| wr_pfn1 | input | 24 | Odd-page frame number |
| wr_v1 | input | 1 | Odd-page valid |
| floor_we | input | 1 | Load the victim floor |
| floor_val | input | 6 | New victim floor |
| rnd_idx | output | 6 | Current victim slot |

## Verification
The bench uses the default parameters: 48 entries, 40-bit virtual and 36-bit physical addresses, and 8-bit identifiers. With these values, one full sweep of the victim pointer, including its wrap, fits in 49 cycles. The 6-bit index also leaves room for out-of-range slot numbers (50) and an out-of-range floor (60). The bench loops over all eight size codes on one entry, so each select bit and each pass-through width is reached.

// File: rtl/tlb_pair_pkg.sv
`timescale 1ns/1ps
package tlb_pair_pkg;
  localparam int VA_W       = 40;
  localparam int PA_W       = 36;
  localparam int ASID_W     = 8;
  localparam int PAGE_SHIFT = 12;
  localparam int SZ_W       = 3;
  localparam int MAX_SZ     = 6;
  localparam int VPN2_W     = VA_W - PAGE_SHIFT - 1;
  localparam int PFN_W      = PA_W - PAGE_SHIFT;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [SZ_W-1:0]   size;
    logic [PFN_W-1:0]  pfn0;
    logic              v0;
    logic [PFN_W-1:0]  pfn1;
    logic              v1;
  } tlb_ent_t;

  // size code, clamped to the largest legal page
  function automatic logic [SZ_W-1:0] size_eff(input logic [SZ_W-1:0] sz);
    return (sz > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : sz;
  endfunction

  // pair-number bits that the tag compare ignores
  function automatic logic [VPN2_W-1:0] pair_dontcare(input logic [SZ_W-1:0] sz);
    logic [SZ_W-1:0] k;
    k = size_eff(sz);
    return (VPN2_W'(1) << (2 * k)) - VPN2_W'(1);
  endfunction

  // address bit choosing the odd half
  function automatic logic [5:0] half_bit(input logic [SZ_W-1:0] sz);
    logic [SZ_W-1:0] k;
    k = size_eff(sz);
    return 6'(PAGE_SHIFT) + 6'(2 * k);
  endfunction

  // physical bits copied straight from the virtual address
  function automatic logic [PA_W-1:0] offset_mask(input logic [SZ_W-1:0] sz);
    return (PA_W'(1) << half_bit(sz)) - PA_W'(1);
  endfunction

  function automatic logic [PA_W-1:0] build_pa(input logic [PFN_W-1:0] pfn,
                                               input logic [PA_W-1:0]  va_low,
                                               input logic [SZ_W-1:0]  sz);
    logic [PA_W-1:0] m;
    m = offset_mask(sz);
    return ({pfn, {PAGE_SHIFT{1'b0}}} & ~m) | (va_low & m);
  endfunction
endpackage

// File: rtl/tlb_ent_match.sv
`timescale 1ns/1ps
module tlb_ent_match
  import tlb_pair_pkg::*;
(
  input  tlb_ent_t          ent,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              tag_hit,
  output logic              odd_half
);
  logic [VPN2_W-1:0] diff;
  logic              id_ok;
  logic              any_valid;

  always_comb begin
    diff      = (ent.vpn2 ^ va[VA_W-1:PAGE_SHIFT+1]) & ~pair_dontcare(ent.size);
    id_ok     = ent.glob || (ent.asid == asid);
    any_valid = ent.v0 || ent.v1;
    tag_hit   = any_valid && id_ok && (diff == '0);
    odd_half  = va[half_bit(ent.size)];
  end
endmodule

// File: rtl/tlb_first_hit.sv
`timescale 1ns/1ps
module tlb_first_hit #(
  parameter int NUM_ENTRIES = 48,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] hits,
  output logic                   found,
  output logic [IDX_W-1:0]       first_idx,
  output logic                   multi
);
  always_comb begin
    first_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) first_idx = IDX_W'(i);
    end
    found = |hits;
    multi = |(hits & (hits - NUM_ENTRIES'(1)));
  end
endmodule

// File: rtl/tlb_victim_ptr.sv
`timescale 1ns/1ps
module tlb_victim_ptr #(
  parameter int NUM_ENTRIES = 48,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             floor_we,
  input  logic [IDX_W-1:0] floor_val,
  output logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] floor_q
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] floor_eff;
  assign floor_eff = (floor_val > TOP) ? TOP : floor_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= TOP;
      floor_q <= '0;
    end else if (floor_we) begin
      ptr     <= TOP;
      floor_q <= floor_eff;
    end else if (ptr <= floor_q) begin
      ptr <= TOP;
    end else begin
      ptr <= ptr - IDX_W'(1);
    end
  end
endmodule

// File: rtl/tlb_pair_xlate.sv
`timescale 1ns/1ps
module tlb_pair_xlate
  import tlb_pair_pkg::*;
#(
  parameter int NUM_ENTRIES = 48,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_inval,
  output logic              lk_multi,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PA_W-1:0]   lk_pa,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic              wr_v0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              wr_v1,
  input  logic              floor_we,
  input  logic [IDX_W-1:0]  floor_val,
  output logic [IDX_W-1:0]  rnd_idx
);
  tlb_ent_t               ent_q [NUM_ENTRIES];
  tlb_ent_t               wr_ent;
  logic [NUM_ENTRIES-1:0] tag_hits;
  logic [NUM_ENTRIES-1:0] odd_sel;
  logic [IDX_W-1:0]       floor_q;
  logic [IDX_W-1:0]       wr_tgt;
  logic                   wr_ok;
  logic                   any_match;
  logic [IDX_W-1:0]       win_idx;
  logic                   multi_match;
  tlb_ent_t               win_ent;
  logic                   win_odd;
  logic                   win_valid;
  logic [PFN_W-1:0]       win_pfn;

  // victim pointer
  tlb_victim_ptr #(.NUM_ENTRIES(NUM_ENTRIES)) u_vptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .floor_we  (floor_we),
    .floor_val (floor_val),
    .ptr       (rnd_idx),
    .floor_q   (floor_q)
  );

  // write path
  always_comb begin
    wr_ent.vpn2 = wr_vpn2;
    wr_ent.asid = wr_asid;
    wr_ent.glob = wr_global;
    wr_ent.size = wr_size;
    wr_ent.pfn0 = wr_pfn0;
    wr_ent.v0   = wr_v0;
    wr_ent.pfn1 = wr_pfn1;
    wr_ent.v1   = wr_v1;
    wr_tgt      = wr_random ? rnd_idx : wr_idx;
    wr_ok       = wr_en && (wr_random || (wr_idx < IDX_W'(NUM_ENTRIES)));
  end

  // per-entry storage and comparators
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (wr_ok && (wr_tgt == IDX_W'(g))) begin
        ent_q[g] <= wr_ent;
      end
    end

    tlb_ent_match u_cmp (
      .ent      (ent_q[g]),
      .va       (lk_va),
      .asid     (lk_asid),
      .tag_hit  (tag_hits[g]),
      .odd_half (odd_sel[g])
    );
  end

  tlb_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_first (
    .hits      (tag_hits),
    .found     (any_match),
    .first_idx (win_idx),
    .multi     (multi_match)
  );

  // result
  always_comb begin
    win_ent   = ent_q[win_idx];
    win_odd   = odd_sel[win_idx];
    win_valid = win_odd ? win_ent.v1 : win_ent.v0;
    win_pfn   = win_odd ? win_ent.pfn1 : win_ent.pfn0;
    lk_miss   = !any_match;
    lk_hit    = any_match && win_valid;
    lk_inval  = any_match && !win_valid;
    lk_multi  = multi_match;
    lk_idx    = win_idx;
    lk_pa     = lk_hit ? build_pa(win_pfn, lk_va[PA_W-1:0], win_ent.size) : '0;
  end
endmodule

// File: rtl/tlb_pair_xlate_chk.sv
`timescale 1ns/1ps
module tlb_pair_xlate_chk
  import tlb_pair_pkg::*;
#(
  parameter int NUM_ENTRIES = 48,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_inval,
  input logic             lk_multi,
  input logic [PA_W-1:0]  lk_pa,
  input logic             floor_we,
  input logic [IDX_W-1:0] rnd_idx,
  input logic [IDX_W-1:0] floor_q
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENTRIES - 1);

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_miss, lk_inval}) == 1);

  assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0) && !lk_multi);

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[PAGE_SHIFT-1:0] == lk_va[PAGE_SHIFT-1:0]));

  assert_multi_matched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> !lk_miss);

  assert_floor_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    floor_we |=> (rnd_idx == TOP));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!floor_we && (rnd_idx > floor_q)) |=> (rnd_idx == IDX_W'($past(rnd_idx) - 1'b1)));

  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!floor_we && (rnd_idx == floor_q)) |=> (rnd_idx == TOP));

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_idx >= floor_q) && (rnd_idx <= TOP));
endmodule

bind tlb_pair_xlate tlb_pair_xlate_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_va    (lk_va),
  .lk_hit   (lk_hit),
  .lk_miss  (lk_miss),
  .lk_inval (lk_inval),
  .lk_multi (lk_multi),
  .lk_pa    (lk_pa),
  .floor_we (floor_we),
  .rnd_idx  (rnd_idx),
  .floor_q  (floor_q)
);

// File: tb/sim_tlb_pair_xlate.sv
`timescale 1ns/1ps
module sim_tlb_pair_xlate;
  localparam int N  = 48;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [39:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit, lk_miss, lk_inval, lk_multi;
  logic [IW-1:0] lk_idx;
  logic [35:0] lk_pa;
  logic        wr_en = 0, wr_random = 0, wr_global = 0, wr_v0 = 0, wr_v1 = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [26:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic [2:0]  wr_size = '0;
  logic [23:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic        floor_we = 0;
  logic [IW-1:0] floor_val = '0;
  logic [IW-1:0] rnd_idx;

  int checks = 0;
  int fails = 0;

  tlb_pair_xlate #(.NUM_ENTRIES(N)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected physical address: frame scaled to bytes, rounded down to page, plus offset
  function automatic logic [35:0] exp_pa(input logic [23:0] pfn, input logic [39:0] va, input int k);
    longint unsigned psz, base;
    int kk;
    kk = (k > 6) ? 6 : k;
    psz = 64'd4096 << (2 * kk);
    base = longint'(pfn) * 64'd4096;
    base = base - (base % psz);
    return 36'(base + (longint'(va) % psz));
  endfunction

  task automatic wr(input logic [IW-1:0] idx, input logic [26:0] vpn2, input logic [7:0] asid,
                    input logic g, input logic [2:0] sz, input logic [23:0] p0, input logic v0,
                    input logic [23:0] p1, input logic v1);
    @(negedge clk);
    wr_idx = idx; wr_vpn2 = vpn2; wr_asid = asid; wr_global = g; wr_size = sz;
    wr_pfn0 = p0; wr_v0 = v0; wr_pfn1 = p1; wr_v1 = v1; wr_random = 0; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  // flags are {hit, miss, inval, multi}
  task automatic look(input logic [39:0] va, input logic [7:0] asid, input logic [3:0] fl,
                      input logic [35:0] pa, input logic [IW-1:0] idx, input bit use_idx,
                      input string tag);
    lk_va = va; lk_asid = asid;
    #1;
    chk({lk_hit, lk_miss, lk_inval, lk_multi} == fl, {tag, " flags"},
        64'({lk_hit, lk_miss, lk_inval, lk_multi}), 64'(fl));
    chk(lk_pa == pa, {tag, " pa"}, 64'(lk_pa), 64'(pa));
    if (use_idx) chk(lk_idx == idx, {tag, " idx"}, 64'(lk_idx), 64'(idx));
  endtask

  task automatic t_reset_and_sweep();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rnd_idx == IW'(N - 1), "R1 pointer at reset", 64'(rnd_idx), 64'(N - 1));
    rst_n = 1;
    look(40'h00_0000_0000, 8'h00, 4'b0100, 36'h0, '0, 0, "R1 empty after reset");
    for (int i = 1; i <= 49; i++) begin
      @(negedge clk);
      chk(rnd_idx == IW'((47 - i + 48) % 48), "R8 sweep", 64'(rnd_idx), 64'((47 - i + 48) % 48));
    end
  endtask

  task automatic t_small_pages();
    wr(6'd5, 27'h1234567, 8'h11, 0, 3'd0, 24'hABCDEF, 1, 24'h135790, 1);
    look({27'h1234567, 1'b0, 12'h9A5}, 8'h11, 4'b1000, {24'hABCDEF, 12'h9A5}, 6'd5, 1, "R2 even half");
    look({27'h1234567, 1'b1, 12'h3C3}, 8'h11, 4'b1000, {24'h135790, 12'h3C3}, 6'd5, 1, "R2 odd half");
  endtask

  task automatic t_sizes();
    logic [39:0] va;
    va = 40'hA5_1234_5678;
    for (int k = 0; k < 8; k++) begin
      int kk;
      logic [23:0] pf;
      kk = (k > 6) ? 6 : k;
      wr(6'd30, va[39:13], 8'h22, 0, 3'(k), 24'h0F1E2D, 1, 24'hF0E1D2, 1);
      pf = va[12 + 2 * kk] ? 24'hF0E1D2 : 24'h0F1E2D;
      look(va, 8'h22, 4'b1000, exp_pa(pf, va, k), 6'd30, 1, $sformatf("R3 size %0d", k));
      look(va ^ (40'd1 << (13 + 2 * kk)), 8'h22, 4'b0100, 36'h0, '0, 0,
           $sformatf("R3 beyond pair size %0d", k));
    end
  endtask

  task automatic t_asid();
    wr(6'd7, 27'h0777777, 8'h33, 0, 3'd0, 24'h000777, 1, 24'h000778, 1);
    look({27'h0777777, 13'h0010}, 8'h34, 4'b0100, 36'h0, '0, 0, "R4 id mismatch");
    look({27'h0777777, 13'h0010}, 8'h33, 4'b1000, {24'h000777, 12'h010}, 6'd7, 1, "R4 id match");
    wr(6'd8, 27'h0888888, 8'h01, 1, 3'd0, 24'h000888, 1, 24'h000889, 1);
    look({27'h0888888, 13'h1020}, 8'hFE, 4'b1000, {24'h000889, 12'h020}, 6'd8, 1, "R4 global");
  endtask

  task automatic t_invalid_and_miss();
    wr(6'd9, 27'h0999999, 8'h44, 0, 3'd0, 24'h000999, 1, 24'h00099A, 0);
    look({27'h0999999, 13'h1abc}, 8'h44, 4'b0010, 36'h0, 6'd9, 1, "R6 odd half invalid");
    look({27'h0999999, 13'h0abc}, 8'h44, 4'b1000, {24'h000999, 12'habc}, 6'd9, 1, "R6 even half valid");
    wr(6'd11, 27'h0BBBBBB, 8'h44, 0, 3'd0, 24'h000BBB, 0, 24'h000BBC, 0);
    look({27'h0BBBBBB, 13'h0001}, 8'h44, 4'b0100, 36'h0, '0, 0, "R6 empty entry no match");
    look(40'hFF_FFFF_F000, 8'h44, 4'b0100, 36'h0, '0, 0, "R5 unmapped");
  endtask

  task automatic t_multi();
    wr(6'd20, 27'h0CCCCCC, 8'h55, 0, 3'd0, 24'h000BBB, 1, 24'h000BBB, 1);
    wr(6'd10, 27'h0CCCCCC, 8'h55, 0, 3'd0, 24'h000AAA, 1, 24'h000AAA, 1);
    look({27'h0CCCCCC, 13'h0123}, 8'h55, 4'b1001, {24'h000AAA, 12'h123}, 6'd10, 1, "R10 lowest wins");
  endtask

  task automatic t_index_bounds();
    wr(6'd50, 27'h0DDDDDD, 8'h66, 0, 3'd0, 24'h000DDD, 1, 24'h000DDD, 1);
    look({27'h0DDDDDD, 13'h0000}, 8'h66, 4'b0100, 36'h0, '0, 0, "R7 out of range ignored");
    wr(6'd47, 27'h0DDDDDD, 8'h66, 0, 3'd0, 24'h000DDE, 1, 24'h000DDE, 1);
    look({27'h0DDDDDD, 13'h0004}, 8'h66, 4'b1000, {24'h000DDE, 12'h004}, 6'd47, 1, "R7 top slot");
  endtask

  task automatic t_random();
    int exp;
    @(negedge clk);
    floor_val = 6'd40; floor_we = 1;
    @(negedge clk);
    floor_we = 0;
    chk(rnd_idx == 6'd47, "R8 floor load restart", 64'(rnd_idx), 64'd47);
    @(negedge clk);
    @(negedge clk);
    chk(rnd_idx == 6'd45, "R8 step after load", 64'(rnd_idx), 64'd45);
    wr_idx = 6'd2; wr_vpn2 = 27'h0EEEEEE; wr_asid = 8'h77; wr_global = 0; wr_size = 3'd0;
    wr_pfn0 = 24'h000EEE; wr_v0 = 1; wr_pfn1 = 24'h000EEF; wr_v1 = 1;
    wr_random = 1; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wr_random = 0;
    look({27'h0EEEEEE, 13'h0777}, 8'h77, 4'b1000, {24'h000EEE, 12'h777}, 6'd45, 1, "R9 random slot");
    exp = 44;
    for (int i = 0; i < 12; i++) begin
      chk(rnd_idx == IW'(exp), "R8 floor wrap", 64'(rnd_idx), 64'(exp));
      exp = (exp == 40) ? 47 : exp - 1;
      @(negedge clk);
    end
  endtask

  task automatic t_floor_clamp();
    @(negedge clk);
    floor_val = 6'd60; floor_we = 1;
    @(negedge clk);
    floor_we = 0;
    for (int i = 0; i < 4; i++) begin
      chk(rnd_idx == 6'd47, "R8 clamped floor", 64'(rnd_idx), 64'd47);
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_and_sweep();
    t_small_pages();
    t_sizes();
    t_asid();
    t_invalid_and_miss();
    t_multi();
    t_index_bounds();
    t_random();
    t_floor_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule